// File: doc/BRIEF.md
# Ethernet destination address filter

This block sits next to a receive MAC and decides, from the destination address alone, whether an incoming frame is kept or discarded. It watches a byte stream. A start strobe marks the first byte of each frame, and the block takes the first six bytes after that strobe as the destination address. Matching runs as the bytes arrive: a running compare against the station address, a running all-ones check for broadcast, and a reflected CRC-32 that is updated one byte per cycle. The result is therefore ready right after the last address byte. The cycle after the sixth byte, the block gives a single-cycle decision. The decision carries an accept flag and a code saying which rule fired.

The receive path supplies a 16-bit control word and three 16-bit station-address words. It also supplies four 16-bit hash words that together form a 64-entry multicast bit table. The control word holds three bits that matter here: receive enable, promiscuous mode and hash enable. All configuration must stay stable while a destination address is being received. Bytes after the sixth, and bytes that arrive with no start strobe, have no effect.

Top module: `dst_addr_filter`

## Requirements
- R1: When control bit 0 (receive enable) is 0, every decision has accept=0 and reason code 0, whatever the address and the other control bits.
- R2: When receive enable is 1 and control bit 6 (promiscuous) is 1, every address is accepted with reason code 1.
- R3: The station address matches when address byte 0 equals station word 0 bits 15:8, byte 1 equals word 0 bits 7:0, bytes 2 and 3 equal word 1 bits 15:8 and 7:0, and bytes 4 and 5 equal word 2 bits 15:8 and 7:0. A match is accepted with reason code 2, and a difference in any single byte prevents the match.
- R4: An address of six 0xFF bytes is accepted with reason code 3.
- R5: With no station or broadcast match and control bit 11 (hash enable) at 0, the frame is rejected with reason code 6.
- R6: The hash index is bits 31:26 of a CRC-32 over the six address bytes. The CRC is fed least significant bit first, starts from 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320, and is not inverted at the end.
- R7: With hash enable set and no station or broadcast match, index bits 5:4 select hash word 0 to 3 (value 0 selects word 0), and index bits 3:0 select a bit in that word. If the bit is 1 the frame is accepted with reason code 4; if it is 0 the frame is rejected with reason code 5.
- R8: The rules are checked in this order: receive enable, then promiscuous, then station, then broadcast, then hash.
- R9: The decision valid flag is high for exactly one cycle: the cycle after the clock edge that takes the sixth address byte. Bytes after the sixth, and bytes with no preceding start strobe, produce no decision.
- R10: A start strobe in the middle of an address discards the partial address and starts a new one from that byte.
- R11: Reset clears all outputs, and accept and reason are 0 in every cycle in which the valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A received byte is present on byte_data |
| frame_start | input | 1 | Marks the current byte as the first byte of a frame |
| byte_data | input | 8 | Received byte |
| rx_ctrl | input | 16 | Control word: bit 0 enable, bit 6 promiscuous, bit 11 hash enable |
| station_w0 | input | 16 | Station address bytes 0 (high) and 1 (low) |
| station_w1 | input | 16 | Station address bytes 2 (high) and 3 (low) |
| station_w2 | input | 16 | Station address bytes 4 (high) and 5 (low) |
| hash_w0 | input | 16 | Hash table bits for index 0 to 15 |
| hash_w1 | input | 16 | Hash table bits for index 16 to 31 |
| hash_w2 | input | 16 | Hash table bits for index 32 to 47 |
| hash_w3 | input | 16 | Hash table bits for index 48 to 63 |
| dec_valid | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Frame is accepted |
| dec_reason | output | 3 | Rule that decided the frame (codes as in R1 to R7) |

## Verification
The hash path gets the most stimulus. For each of many multicast addresses, the bench builds a table with only the indexed bit set and then one with every bit except that one. A CRC fed in the wrong bit order, a wrong or reversed word select, or an off-by-one index fails one of the two runs at once. Station matching is checked one byte at a time, so swapped bytes within a word fail to match and a compare that skips one byte wrongly matches. Priority is tested with a station address of all ones and with promiscuous mode on a station address. Timing cases check that the strobe comes exactly six cycles after the start, appears once even when trailing bytes follow, and starts over after a restart in mid-address. A late or repeated strobe, or a partial address that is kept, shows up as a wrong pulse count or position.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int CTRL_W     = 16;
  localparam int BIT_EN     = 0;
  localparam int BIT_PROM   = 6;
  localparam int BIT_HASH   = 11;
  localparam int CRC_W      = 32;
  localparam int HIDX_W     = 6;
  localparam int HWORD_W    = 16;
  localparam int HWORDS     = (1 << HIDX_W) / HWORD_W;
  localparam int HSEL_W     = $clog2(HWORDS);
  localparam int HBIT_W     = $clog2(HWORD_W);

  typedef enum logic [2:0] {
    RSN_OFF       = 3'd0,
    RSN_PROMISC   = 3'd1,
    RSN_STATION   = 3'd2,
    RSN_BCAST     = 3'd3,
    RSN_HASH_HIT  = 3'd4,
    RSN_HASH_MISS = 3'd5,
    RSN_NO_MATCH  = 3'd6
  } reason_e;

  function automatic logic [CRC_W-1:0] crc_byte_step(
    input logic [CRC_W-1:0] cur,
    input logic [7:0]       din,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] r;
    r = cur ^ {{(CRC_W-8){1'b0}}, din};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/dfilt_byte_cnt.sv
module dfilt_byte_cnt #(
  parameter int NBYTES = 6,
  localparam int IDX_W = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             frame_start,
  output logic             take,
  output logic             last_take,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // A start strobe forces the byte index to zero; otherwise the stored count.
  always_comb begin
    idx       = frame_start ? '0 : cnt_q;
    take      = byte_valid && (frame_start || (cnt_q < IDX_W'(NBYTES)));
    last_take = take && (idx == IDX_W'(NBYTES - 1));
    cnt_en    = take;
    cnt_d     = idx + 1'b1;
  end

  // Reset parks the counter at NBYTES so stray bytes are ignored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= IDX_W'(NBYTES);
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dfilt_crc.sv
module dfilt_crc
  import dfilt_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
  parameter logic [CRC_W-1:0] SEED = 32'hFFFFFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             frame_start,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc_now
);
  logic [CRC_W-1:0] crc_q, base;

  always_comb begin
    base    = frame_start ? SEED : crc_q;
    crc_now = crc_byte_step(base, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= SEED;
    else if (take) crc_q <= crc_now;
  end
endmodule

// File: rtl/dfilt_addr_cmp.sv
module dfilt_addr_cmp #(
  parameter int NBYTES = 6,
  localparam int IDX_W = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              frame_start,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        din,
  input  logic [8*NBYTES-1:0] station,
  output logic              sta_now,
  output logic              bc_now
);
  logic [NBYTES-1:0][7:0] lane;
  logic [7:0]             expect_b;
  logic                   sta_q, bc_q, sta_base, bc_base;

  // Byte 0 sits in the top byte of the packed station vector.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = station[8*(NBYTES-g)-1 -: 8];
  end

  always_comb begin
    expect_b = 8'h00;
    for (int k = 0; k < NBYTES; k++) begin
      if (idx == IDX_W'(k)) expect_b = lane[k];
    end
    sta_base = frame_start ? 1'b1 : sta_q;
    bc_base  = frame_start ? 1'b1 : bc_q;
    sta_now  = sta_base && (din == expect_b);
    bc_now   = bc_base && (din == 8'hFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (take) begin
      sta_q <= sta_now;
      bc_q  <= bc_now;
    end
  end
endmodule

// File: rtl/dfilt_decide.sv
module dfilt_decide
  import dfilt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          last_take,
  input  logic                          en,
  input  logic                          prom,
  input  logic                          hash_en,
  input  logic                          sta_now,
  input  logic                          bc_now,
  input  logic [CRC_W-1:0]              crc_now,
  input  logic [HWORDS-1:0][HWORD_W-1:0] htab,
  output logic                          dec_valid,
  output logic                          dec_accept,
  output logic [2:0]                    dec_reason
);
  logic [HIDX_W-1:0]  hidx;
  logic [HWORD_W-1:0] hword;
  logic               hbit, acc_d, upd;
  reason_e            rsn_d;
  logic               unused_crc;

  assign unused_crc = ^crc_now[CRC_W-HIDX_W-1:0];

  always_comb begin
    hidx  = crc_now[CRC_W-1 -: HIDX_W];
    hword = htab[hidx[HIDX_W-1 -: HSEL_W]];
    hbit  = hword[hidx[HBIT_W-1:0]];
    acc_d = 1'b0;
    rsn_d = RSN_NO_MATCH;
    if (!en) begin
      rsn_d = RSN_OFF;
    end else if (prom) begin
      acc_d = 1'b1;
      rsn_d = RSN_PROMISC;
    end else if (sta_now) begin
      acc_d = 1'b1;
      rsn_d = RSN_STATION;
    end else if (bc_now) begin
      acc_d = 1'b1;
      rsn_d = RSN_BCAST;
    end else if (hash_en) begin
      acc_d = hbit;
      rsn_d = hbit ? RSN_HASH_HIT : RSN_HASH_MISS;
    end
    upd = last_take || dec_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= 3'd0;
    end else if (upd) begin
      dec_valid  <= last_take;
      dec_accept <= last_take && acc_d;
      dec_reason <= last_take ? rsn_d : 3'd0;
    end
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import dfilt_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320,
  parameter logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic        frame_start,
  input  logic [7:0]  byte_data,
  input  logic [15:0] rx_ctrl,
  input  logic [15:0] station_w0,
  input  logic [15:0] station_w1,
  input  logic [15:0] station_w2,
  input  logic [15:0] hash_w0,
  input  logic [15:0] hash_w1,
  input  logic [15:0] hash_w2,
  input  logic [15:0] hash_w3,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic [2:0]  dec_reason
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);

  logic                           take, last_take, sta_now, bc_now;
  logic [IDX_W-1:0]               idx;
  logic [CRC_W-1:0]               crc_now;
  logic [HWORDS-1:0][HWORD_W-1:0] htab;
  logic                           unused_ctrl;

  assign htab        = {hash_w3, hash_w2, hash_w1, hash_w0};
  assign unused_ctrl = ^rx_ctrl;

  dfilt_byte_cnt #(.NBYTES(ADDR_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
    .frame_start(frame_start), .take(take), .last_take(last_take), .idx(idx)
  );

  dfilt_crc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .frame_start(frame_start),
    .din(byte_data), .crc_now(crc_now)
  );

  dfilt_addr_cmp #(.NBYTES(ADDR_BYTES)) u_cmp (
    .clk(clk), .rst_n(rst_n), .take(take), .frame_start(frame_start),
    .idx(idx), .din(byte_data),
    .station({station_w0, station_w1, station_w2}),
    .sta_now(sta_now), .bc_now(bc_now)
  );

  dfilt_decide u_dec (
    .clk(clk), .rst_n(rst_n), .last_take(last_take),
    .en(rx_ctrl[BIT_EN]), .prom(rx_ctrl[BIT_PROM]), .hash_en(rx_ctrl[BIT_HASH]),
    .sta_now(sta_now), .bc_now(bc_now), .crc_now(crc_now), .htab(htab),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
  );
endmodule

// File: rtl/dfilt_checker.sv
module dfilt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic [15:0] rx_ctrl,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic [2:0]  dec_reason
);
  AST_OFF_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !$past(rx_ctrl[0])) |-> (!dec_accept && dec_reason == 3'd0)); // R1

  AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(rx_ctrl[0]) && $past(rx_ctrl[6])) |-> (dec_accept && dec_reason == 3'd1)); // R2

  AST_NO_HASH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !$past(rx_ctrl[11])) |-> (dec_reason != 3'd4 && dec_reason != 3'd5)); // R5

  AST_ACCEPT_HAS_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_accept) |-> (dec_reason >= 3'd1 && dec_reason <= 3'd4)); // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R9

  AST_PULSE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(byte_valid)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_reason == 3'd0)); // R11
endmodule

bind dst_addr_filter dfilt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_ctrl(rx_ctrl),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
);

// File: tb/dst_addr_filter_test.sv
`timescale 1ns/1ps
module dst_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid, frame_start;
  logic [7:0]  byte_data;
  logic [15:0] rx_ctrl, st0, st1, st2, h0, h1, h2, h3;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_reason;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int         g_pulses, g_pos;
  logic       g_acc;
  logic [2:0] g_rsn;

  always #4 clk = ~clk;

  dst_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .frame_start(frame_start),
    .byte_data(byte_data), .rx_ctrl(rx_ctrl),
    .station_w0(st0), .station_w1(st1), .station_w2(st2),
    .hash_w0(h0), .hash_w1(h1), .hash_w2(h2), .hash_w3(h3),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
  );

  function automatic logic [5:0] hidx_of(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = a[47-8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ b[k];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic [3:0] expect_of(input logic [47:0] a);
    logic [63:0] tab;
    logic [5:0]  ix;
    tab = {h3, h2, h1, h0};
    if (!rx_ctrl[0])                  return {1'b0, 3'd0};
    if (rx_ctrl[6])                   return {1'b1, 3'd1};
    if (a == {st0, st1, st2})         return {1'b1, 3'd2};
    if (a == 48'hFFFF_FFFF_FFFF)      return {1'b1, 3'd3};
    if (!rx_ctrl[11])                 return {1'b0, 3'd6};
    ix = hidx_of(a);
    return tab[ix] ? {1'b1, 3'd4} : {1'b0, 3'd5};
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic observe(input int k);
    if (dec_valid) begin
      g_pulses++;
      if (g_pulses == 1) begin
        g_pos = k;
        g_acc = dec_accept;
        g_rsn = dec_reason;
      end
    end
  endtask

  // pre: junk bytes before the real start (first of them carries a start).
  // nostart: send the address without any start strobe.
  task automatic run_frame(input logic [47:0] a, input int pre, input int extra, input bit nostart);
    int k;
    g_pulses = 0; g_pos = -1; g_acc = 1'b0; g_rsn = 3'd0;
    k = 0;
    for (int i = 0; i < pre + 6 + extra; i++) begin
      @(negedge clk);
      observe(k);
      byte_valid  = 1'b1;
      frame_start = !nostart && ((i == 0) || (i == pre));
      if (i < pre)          byte_data = 8'h5A ^ 8'(i);
      else if (i < pre + 6) byte_data = a[47-8*(i-pre) -: 8];
      else                  byte_data = 8'hFF;
      k++;
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      observe(k);
      byte_valid = 1'b0; frame_start = 1'b0;
      k++;
    end
  endtask

  task automatic frame_expect(input string req, input logic [47:0] a);
    logic [3:0] e;
    e = expect_of(a);
    run_frame(a, 0, 0, 1'b0);
    check(req, g_pulses, 1);
    check(req, {g_acc, g_rsn}, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  ix;
    logic [63:0] tab;
    rst_n = 1'b0; byte_valid = 1'b0; frame_start = 1'b0; byte_data = 8'h00;
    rx_ctrl = 16'h0000;
    st0 = 16'h0A1B; st1 = 16'h2C3D; st2 = 16'h4E5F;
    h0 = 16'h0; h1 = 16'h0; h2 = 16'h0; h3 = 16'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {dec_valid, dec_accept, dec_reason}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 disabled: even with promisc and a station address
    rx_ctrl = 16'h0840;
    frame_expect("R1", 48'h0A1B_2C3D_4E5F);
    frame_expect("R1", 48'hFFFF_FFFF_FFFF);

    // R2 promiscuous over several patterns
    rx_ctrl = 16'h0041;
    for (int n = 0; n < 8; n++) frame_expect("R2", {8'(n * 37), 40'h12_3456_789A} ^ 48'(n));

    // R3 station exact, then single-byte differences (hash off -> code 6, R5)
    rx_ctrl = 16'h0001;
    frame_expect("R3", 48'h0A1B_2C3D_4E5F);
    for (int b = 0; b < 6; b++) begin
      a = 48'h0A1B_2C3D_4E5F ^ (48'h01 << (8 * b));
      frame_expect("R3", a);
      check("R5", {g_acc, g_rsn}, {1'b0, 3'd6});
    end
    // R3 swapped bytes inside a word must not match
    frame_expect("R3", 48'h1B0A_2C3D_4E5F);

    // R4 broadcast
    frame_expect("R4", 48'hFFFF_FFFF_FFFF);
    check("R4", {g_acc, g_rsn}, {1'b1, 3'd3});

    // R8 priority: station beats broadcast, promisc beats station
    st0 = 16'hFFFF; st1 = 16'hFFFF; st2 = 16'hFFFF;
    frame_expect("R8", 48'hFFFF_FFFF_FFFF);
    check("R8", g_rsn, 3'd2);
    st0 = 16'h0A1B; st1 = 16'h2C3D; st2 = 16'h4E5F;
    rx_ctrl = 16'h0841;
    frame_expect("R8", 48'h0A1B_2C3D_4E5F);
    check("R8", g_rsn, 3'd1);
    // R8 broadcast beats hash miss
    rx_ctrl = 16'h0801;
    frame_expect("R8", 48'hFFFF_FFFF_FFFF);

    // R6 R7 hash: one-hot table then all-but-one table per address
    for (int n = 0; n < 128; n++) begin
      a  = {8'h01, 8'h00, 8'h5E, 8'(n * 3), 8'(n ^ 8'hC3), 8'(n * 11 + 1)};
      ix = hidx_of(a);
      tab = 64'd1 << ix;
      {h3, h2, h1, h0} = tab;
      frame_expect("R7", a);
      check("R6", {g_acc, g_rsn}, {1'b1, 3'd4});
      {h3, h2, h1, h0} = ~tab;
      frame_expect("R7", a);
      check("R6", {g_acc, g_rsn}, {1'b0, 3'd5});
    end

    // R9 timing with trailing bytes: one pulse six cycles after start
    {h3, h2, h1, h0} = 64'hFFFF_FFFF_FFFF_FFFF;
    run_frame(48'h0A1B_2C3D_4E5F, 0, 4, 1'b0);
    check("R9", g_pulses, 1);
    check("R9", g_pos, 6);
    check("R9", {g_acc, g_rsn}, {1'b1, 3'd2});
    // R9 no start strobe -> no decision
    run_frame(48'hFFFF_FFFF_FFFF, 0, 0, 1'b1);
    check("R9", g_pulses, 0);

    // R10 restart mid-address
    for (int p = 1; p < 6; p++) begin
      run_frame(48'hFFFF_FFFF_FFFF, p, 0, 1'b0);
      check("R10", g_pulses, 1);
      check("R10", g_pos, p + 6);
      check("R10", {g_acc, g_rsn}, {1'b1, 3'd3});
    end

    // R11 quiet between frames
    @(negedge clk);
    check("R11", {dec_valid, dec_accept, dec_reason}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule